// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the 16-bit status and control word for one root port of a full/low-speed USB host controller. It also contains the small amount of port-side logic that keeps that word up to date. Software reaches it through a plain register write strobe with two byte enables and a combinational read-back. On the port side it watches device presence, a fault indication, the two data lines, a bus-busy flag and a frame-timing strobe that marks the end-of-frame check point (EOF2).

It tracks connect changes in sticky flags that software clears by writing 1. It enables the port only on software request, and defers that change while a transaction is on the bus. Hardware disables the port on a disconnect, or on a fault seen at EOF2. It samples the line state once per frame. It runs the resume sequence in both directions. If a K-state persists on a suspended, enabled port for a qualification time, hardware sets the resume bit. While the resume bit is set and the port is suspended, the block asks the transceiver to drive K. When software clears the resume bit, the block asks for a low-speed EOP, and the bit stays set until that EOP is reported done.

Top module: `usb_port_ctl`

## Requirements
- R1: After reset the read value is 0x0080: bit 7 always reads 1, and bits 15:13, 11:8 and every status bit read 0. port_en, drive_k and eop_start are 0.
- R2: Bit 0 (connect state, read-only) shows dev_present as sampled at the previous clock edge. Writes do not change it.
- R3: Bit 1 (connect change) is set at the edge where bit 0 changes value, and stays set through further changes. A write with reg_be[0]=1 and data bit 1 = 1 clears it. Writing 0 to it has no effect. A set in the same cycle as a clear wins.
- R4: Bit 2 (port enable, also output port_en) takes the value of data bit 2 on a write with reg_be[0]=1. If bus_busy is 1, the new value is held pending and applied at the first edge where bus_busy is 0.
- R5: When port_en is 1, hardware clears it and sets bit 3 (enable change) in either of two cases: dev_present is 0 at an edge, or fault and eof2 are both 1 at an edge. A disable by software does not set bit 3. Bit 3 is cleared by writing 1 to data bit 3 with reg_be[0]=1, and writing 0 to it has no effect.
- R6: Bits 5:4 hold {line_dm, line_dp} captured at edges where eof2 is 1 (bit 4 = D+, bit 5 = D-). At other edges they hold their value.
- R7: Bit 12 (suspend) is read/write through reg_be[1]. reg_be[0] gates bits 1, 2, 3 and 6. A byte whose enable is 0 is left unchanged.
- R8: A write of 1 to bit 6 (resume) with reg_be[0]=1 sets it. drive_k is 1 exactly while bit 6 is set in its driving phase, bit 12 is 1 and port_en is 1.
- R9: When bit 12 and port_en are both 1 and bit 6 is 0, K on the line (line_dp=0, line_dm=1) sampled at CLK_MHZ*K_US consecutive edges sets bit 6. Any non-K sample, or leaving the suspended state, restarts the count.
- R10: Writing 0 to bit 6 while it is set in its driving phase makes eop_start 1 for exactly one cycle. Bit 6 then stays 1, ignoring writes, until eop_done is 1 at an edge, after which it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register value |
| dev_present | input | 1 | Device attached to the port |
| fault | input | 1 | Overcurrent or other port fault |
| eof2 | input | 1 | End-of-frame check point strobe |
| bus_busy | input | 1 | Transaction in progress on the port |
| line_dp | input | 1 | D+ logic level |
| line_dm | input | 1 | D- logic level |
| eop_done | input | 1 | Low-speed EOP has finished |
| port_en | output | 1 | Port enabled |
| drive_k | output | 1 | Request to drive resume K-state |
| eop_start | output | 1 | One-cycle request to send a low-speed EOP |

## Verification
The bench builds the block with CLK_MHZ=1 and K_US=32, so the resume qualification window is 32 cycles rather than thousands. This lets the bench reach both sides of that boundary directly: a K run one cycle short, a full-length run, and a run while not suspended. The remaining parameters keep their defaults, and the connect, line-state and suspend bits are driven with seeded random traffic that is compared each cycle against a bench model.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRIVE = 2'd1,
    RS_EOP   = 2'd2
  } rsm_state_e;

  localparam int unsigned B_CCS  = 0;
  localparam int unsigned B_CSC  = 1;
  localparam int unsigned B_PEN  = 2;
  localparam int unsigned B_PEC  = 3;
  localparam int unsigned B_LSP  = 4;
  localparam int unsigned B_LSM  = 5;
  localparam int unsigned B_RSM  = 6;
  localparam int unsigned B_ONE  = 7;
  localparam int unsigned B_SUSP = 12;
  localparam int unsigned REG_W  = 16;
endpackage

// File: rtl/prt_conn.sv
module prt_conn (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_present,
  input  logic clr_csc,
  output logic ccs,
  output logic csc
);
  logic ccs_d, csc_d;

  always_comb begin
    ccs_d = dev_present;
    csc_d = (ccs != dev_present) | (csc & ~clr_csc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccs <= 1'b0;
      csc <= 1'b0;
    end else begin
      ccs <= ccs_d;
      csc <= csc_d;
    end
  end

  // R3
  csc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csc && !clr_csc) |=> csc);

  // R3
  csc_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ccs) || $fell(ccs)) |-> csc);
endmodule

// File: rtl/prt_enable.sv
module prt_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_req,
  input  logic sw_val,
  input  logic bus_busy,
  input  logic dev_present,
  input  logic fault,
  input  logic eof2,
  input  logic clr_pec,
  output logic port_en,
  output logic pec
);
  logic pend_v, pend_val;
  logic en_d, pec_d, pend_v_d, pend_val_d;
  logic hw_dis, req_v, req_val;

  always_comb begin
    hw_dis  = port_en & (~dev_present | (fault & eof2));
    req_v   = sw_req | pend_v;
    req_val = sw_req ? sw_val : pend_val;
  end

  always_comb begin
    en_d       = port_en;
    pec_d      = pec & ~clr_pec;
    pend_v_d   = pend_v;
    pend_val_d = pend_val;
    if (hw_dis) begin
      en_d     = 1'b0;
      pec_d    = 1'b1;
      pend_v_d = 1'b0;
    end else if (req_v) begin
      if (!bus_busy) begin
        en_d     = req_val;
        pend_v_d = 1'b0;
      end else begin
        pend_v_d   = 1'b1;
        pend_val_d = req_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en  <= 1'b0;
      pec      <= 1'b0;
      pend_v   <= 1'b0;
      pend_val <= 1'b0;
    end else begin
      port_en  <= en_d;
      pec      <= pec_d;
      pend_v   <= pend_v_d;
      pend_val <= pend_val_d;
    end
  end

  // R4
  en_rise_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_en) |-> $past(!bus_busy));

  // R4
  en_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !hw_dis) |=> port_en == $past(port_en));

  // R5
  pec_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pec) |-> $fell(port_en));
endmodule

// File: rtl/prt_resume.sv
module prt_resume
  import prt_pkg::*;
#(
  parameter int unsigned KCYC = 1536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic suspended,
  input  logic line_dp,
  input  logic line_dm,
  input  logic eop_done,
  output logic rsm,
  output logic drive_k,
  output logic eop_start
);
  localparam int unsigned CW = $clog2(KCYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(KCYC - 1);

  rsm_state_e state, state_d;
  logic [CW-1:0] cnt, cnt_d;
  logic eop_d, is_k;

  always_comb begin
    is_k    = ~line_dp & line_dm;
    state_d = state;
    cnt_d   = '0;
    eop_d   = 1'b0;
    unique case (state)
      RS_IDLE: begin
        if (sw_set) begin
          state_d = RS_DRIVE;
        end else if (suspended && is_k) begin
          if (cnt == CNT_LAST) state_d = RS_DRIVE;
          else                 cnt_d   = cnt + 1'b1;
        end
      end
      RS_DRIVE: begin
        if (sw_clr) begin
          state_d = RS_EOP;
          eop_d   = 1'b1;
        end
      end
      RS_EOP: begin
        if (eop_done) state_d = RS_IDLE;
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RS_IDLE;
      cnt       <= '0;
      eop_start <= 1'b0;
    end else begin
      state     <= state_d;
      cnt       <= cnt_d;
      eop_start <= eop_d;
    end
  end

  assign rsm     = (state != RS_IDLE);
  assign drive_k = (state == RS_DRIVE) & suspended;

  // R10
  eop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_start |=> !eop_start);

  // R10
  rsm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_EOP && !eop_done) |=> rsm);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(KCYC));

  // R8
  drive_needs_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_k |-> (rsm && suspended && !eop_start));
endmodule

// File: rtl/usb_port_ctl.sv
module usb_port_ctl
  import prt_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 48,
  parameter int unsigned K_US    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        dev_present,
  input  logic        fault,
  input  logic        eof2,
  input  logic        bus_busy,
  input  logic        line_dp,
  input  logic        line_dm,
  input  logic        eop_done,
  output logic        port_en,
  output logic        drive_k,
  output logic        eop_start
);
  localparam int unsigned KCYC = CLK_MHZ * K_US;

  logic wr_lo, wr_hi;
  logic ccs, csc, pec, rsm;
  logic susp, susp_d;
  logic [1:0] ls, ls_d;
  logic unused_bits;

  assign wr_lo = reg_wr & reg_be[0];
  assign wr_hi = reg_wr & reg_be[1];
  assign unused_bits = ^{reg_wdata[15:13], reg_wdata[11:7], reg_wdata[5:4], reg_wdata[0]};

  prt_conn u_conn (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_present (dev_present),
    .clr_csc     (wr_lo & reg_wdata[B_CSC]),
    .ccs         (ccs),
    .csc         (csc)
  );

  prt_enable u_enable (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_req      (wr_lo),
    .sw_val      (reg_wdata[B_PEN]),
    .bus_busy    (bus_busy),
    .dev_present (dev_present),
    .fault       (fault),
    .eof2        (eof2),
    .clr_pec     (wr_lo & reg_wdata[B_PEC]),
    .port_en     (port_en),
    .pec         (pec)
  );

  prt_resume #(.KCYC(KCYC)) u_resume (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_set    (wr_lo & reg_wdata[B_RSM]),
    .sw_clr    (wr_lo & ~reg_wdata[B_RSM]),
    .suspended (susp & port_en),
    .line_dp   (line_dp),
    .line_dm   (line_dm),
    .eop_done  (eop_done),
    .rsm       (rsm),
    .drive_k   (drive_k),
    .eop_start (eop_start)
  );

  always_comb begin
    susp_d = wr_hi ? reg_wdata[B_SUSP] : susp;
    ls_d   = eof2 ? {line_dm, line_dp} : ls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp <= 1'b0;
      ls   <= 2'b00;
    end else begin
      susp <= susp_d;
      ls   <= ls_d;
    end
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[B_CCS]  = ccs;
    reg_rdata[B_CSC]  = csc;
    reg_rdata[B_PEN]  = port_en;
    reg_rdata[B_PEC]  = pec;
    reg_rdata[B_LSP]  = ls[0];
    reg_rdata[B_LSM]  = ls[1];
    reg_rdata[B_RSM]  = rsm;
    reg_rdata[B_ONE]  = 1'b1;
    reg_rdata[B_SUSP] = susp;
  end

  // R6
  ls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eof2 |=> ls == $past(ls));

  // R7
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> susp == $past(susp));
endmodule

// File: tb/usb_port_ctl_bench.sv
`timescale 1ns/1ps
module usb_port_ctl_bench;
  localparam int unsigned KQ = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_be = 2'b00;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic dev_present = 1'b0, fault = 1'b0, eof2 = 1'b0, bus_busy = 1'b0;
  logic line_dp = 1'b1, line_dm = 1'b0, eop_done = 1'b0;
  logic port_en, drive_k, eop_start;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  usb_port_ctl #(.CLK_MHZ(1), .K_US(32)) u_usb_port_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_present(dev_present),
    .fault(fault), .eof2(eof2), .bus_busy(bus_busy), .line_dp(line_dp),
    .line_dm(line_dm), .eop_done(eop_done), .port_en(port_en),
    .drive_k(drive_k), .eop_start(eop_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl_next(input logic [15:0] cur, input logic dev,
      input logic dp, input logic dm, input logic eof, input logic wr,
      input logic [1:0] be, input logic [15:0] wd);
    logic [15:0] n;
    n = cur;
    n[0] = dev;
    n[1] = (cur[0] != dev) | (cur[1] & ~(wr & be[0] & wd[1]));
    if (eof) n[5:4] = {dm, dp};
    if (wr & be[1]) n[12] = wd[12];
    return n;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    logic [31:0] r;
    void'($urandom(32'h5eed_0042));
    cyc(2);
    // R1 reset value
    chk("R1 reset rdata", reg_rdata, 16'h0080);
    chk("R1 reset outs", {port_en, drive_k, eop_start}, 3'b000);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 after release", reg_rdata, 16'h0080);

    // R2 R3 R6 R7 random traffic, enable/resume bits kept untouched
    exp = 16'h0080;
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      dev_present = (r[3:0] < 4'd3) ? ~dev_present : dev_present;
      line_dp = r[4]; line_dm = r[5]; eof2 = r[6];
      bus_busy = r[7];
      reg_wr = r[8] & r[9];
      reg_be = r[11:10];
      reg_wdata = r[31:16] & 16'hFFBB;
      exp = mdl_next(exp, dev_present, line_dp, line_dm, eof2, reg_wr, reg_be, reg_wdata);
      @(negedge clk);
      chk("R2 R3 R6 R7 random", reg_rdata & 16'h10B3, exp & 16'h10B3);
    end
    reg_wr = 1'b0; eof2 = 1'b0; bus_busy = 1'b0;
    line_dp = 1'b1; line_dm = 1'b0;
    dev_present = 1'b1;
    cyc(2);
    wr(2'b11, 16'h000A);
    chk("R3 clear", reg_rdata & 16'h100B, 16'h0001);

    // R3 write 0 does not clear, sticky over two changes
    dev_present = 1'b0; cyc(1); dev_present = 1'b1; cyc(1);
    wr(2'b01, 16'h0000);
    chk("R3 sticky w0", reg_rdata[1:0], 2'b11);
    wr(2'b01, 16'h0002);
    chk("R3 w1c", reg_rdata[1:0], 2'b01);

    // R7 byte enable gating of enable bit
    wr(2'b10, 16'h0004);
    chk("R7 be gate", port_en, 1'b0);
    // R4 enable
    wr(2'b01, 16'h0004);
    chk("R4 enable", {port_en, reg_rdata[2]}, 2'b11);
    // R4 deferred disable while busy
    bus_busy = 1'b1;
    wr(2'b01, 16'h0000);
    cyc(2);
    chk("R4 held while busy", port_en, 1'b1);
    bus_busy = 1'b0;
    cyc(1);
    chk("R4 applied after busy", port_en, 1'b0);
    chk("R5 sw disable no flag", reg_rdata[3], 1'b0);

    // R5 fault needs eof2
    wr(2'b01, 16'h0004);
    fault = 1'b1; cyc(2);
    chk("R5 fault without eof2", port_en, 1'b1);
    eof2 = 1'b1; cyc(1); eof2 = 1'b0; fault = 1'b0;
    chk("R5 fault at eof2", {port_en, reg_rdata[3]}, 2'b01);
    wr(2'b01, 16'h0000);
    chk("R5 w0 keeps pec", reg_rdata[3], 1'b1);
    wr(2'b01, 16'h0008);
    chk("R5 w1c pec", reg_rdata[3], 1'b0);
    // R5 disconnect
    wr(2'b01, 16'h0004);
    dev_present = 1'b0; cyc(1);
    chk("R5 disconnect", {port_en, reg_rdata[3], reg_rdata[1]}, 3'b011);
    dev_present = 1'b1; cyc(1);
    wr(2'b01, 16'h000A);

    // R6 line change without eof2 ignored
    line_dp = 1'b0; line_dm = 1'b1; cyc(3);
    chk("R6 no eof2 hold", reg_rdata[5:4], 2'b01);
    line_dp = 1'b1; line_dm = 1'b0; cyc(1);

    // R9 not suspended: long K does nothing
    wr(2'b01, 16'h0004);
    line_dp = 1'b0; line_dm = 1'b1; cyc(KQ + 8);
    chk("R9 no suspend", reg_rdata[6], 1'b0);
    line_dp = 1'b1; line_dm = 1'b0;
    wr(2'b11, 16'h1004);
    // R9 one short
    line_dp = 1'b0; line_dm = 1'b1; cyc(KQ - 1);
    line_dp = 1'b1; line_dm = 1'b0; cyc(1);
    chk("R9 short K", {reg_rdata[6], drive_k}, 2'b00);
    // R9 full length
    line_dp = 1'b0; line_dm = 1'b1; cyc(KQ - 1);
    chk("R9 before boundary", reg_rdata[6], 1'b0);
    cyc(1);
    line_dp = 1'b1; line_dm = 1'b0;
    chk("R9 detect", reg_rdata[6], 1'b1);
    chk("R8 drive_k hw", drive_k, 1'b1);
    // R10 clear starts EOP
    wr(2'b11, 16'h1004);
    chk("R10 eop_start", {eop_start, reg_rdata[6], drive_k}, 3'b110);
    cyc(1);
    chk("R10 pulse one cycle", {eop_start, reg_rdata[6]}, 2'b01);
    wr(2'b11, 16'h1044);
    eop_done = 1'b1; cyc(1); eop_done = 1'b0;
    chk("R10 done clears", reg_rdata[6], 1'b0);
    cyc(2);
    chk("R10 write during eop ignored", {reg_rdata[6], drive_k}, 2'b00);

    // R8 software resume, drive_k follows suspend
    wr(2'b11, 16'h1044);
    chk("R8 sw set", {reg_rdata[6], drive_k}, 2'b11);
    wr(2'b10, 16'h0000);
    chk("R8 drive_k off when not suspended", {reg_rdata[6], drive_k}, 2'b10);
    wr(2'b01, 16'h0004);
    chk("R10 clear gives pulse", eop_start, 1'b1);
    eop_done = 1'b1; cyc(1); eop_done = 1'b0;
    chk("R10 final", reg_rdata[6], 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule